// File: doc/BRIEF.md
# Transient Fault-Injection Campaign Sequencer

This block runs an exhaustive single-event-transient injection campaign against a delay-modelled circuit under test that has a fault-free golden copy beside it. It owns the registers that hold each test vector at the circuit inputs. It also owns the serial chain that picks which gate receives the fault, and the inject line that creates the transient. Time is counted in quanta. A functional period is a whole number of quanta and is chosen slightly longer than the critical path of the circuit.

For each selected gate the sequencer shifts a one-hot mask into the chain. For each test vector it first runs one quiet settling period so that the delay counters reach a steady state. It then runs an injection period in which the inject line is raised for a set number of quanta, starting at a chosen quantum. At the end of that period the faulty and golden outputs are latched and compared, and only a latched difference adds to the error count. The start instant sweeps every quantum of the period. The full sweep over gates, vectors and instants is repeated for every pulse width. A done flag marks the end of the campaign.

Top module: `set_camp_ctrl`

## Requirements
- R1: After reset, vec_o, scan_en_o, scan_bit_o, inject_o, err_cnt_o and done_o are all zero, and the block stays idle until start_i is seen high.
- R2: Each time the target gate changes, scan_en_o is high for exactly N_GATES cycles. During that load scan_bit_o is high only in load cycle N_GATES-1-t (cycles counted from 0), so the single one lands at chain position t. Targets go in ascending order 0..N_GATES-1, and inject_o is never high while the chain is loading.
- R3: Each vector application starts with a settling period of PERIOD_Q cycles in which inject_o stays low.
- R4: In the injection period of PERIOD_Q quanta (q = 0..PERIOD_Q-1), inject_o is high exactly for quanta with s <= q < s+w, where s is the start instant and w is the pulse width. A pulse that would run past the end of the period is cut off. The start instant s sweeps 0..PERIOD_Q-1.
- R5: The pulse width is w = W_MIN + k*W_STEP for k = 0..N_WIDTHS-1, on the outermost loop. The complete target, vector and instant sweep is repeated for each width.
- R6: vec_o carries the vector index, 0..N_VECTORS-1. It is loaded on entry to a settling period and held constant through settling, injection and compare. The loop order is width > target > vector > instant, with the instant innermost.
- R7: The faulty and golden outputs are latched at the clock edge that ends the last injection quantum. One compare cycle follows. err_cnt_o rises by one in the cycle after that compare cycle when the latched values differ, and is unchanged when they match.
- R8: err_cnt_o saturates at its all-ones value and never wraps or decreases.
- R9: After the compare cycle of the last width, target, vector and instant combination, done_o goes high. It then stays high with inject_o and scan_en_o low until reset.
- R10: start_i has no effect while a campaign is running or after done_o is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Time-quantum clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts a campaign when idle |
| fault_out_i | input | OUT_W | Outputs of the circuit copy under injection |
| gold_out_i | input | OUT_W | Outputs of the fault-free golden copy |
| vec_o | output | VEC_W | Registered test vector at the circuit inputs |
| scan_en_o | output | 1 | Shift enable for the target-mask chain |
| scan_bit_o | output | 1 | Serial data into the target-mask chain |
| inject_o | output | 1 | Transient inject pulse |
| err_cnt_o | output | CNT_W | Saturating count of latched mismatches |
| done_o | output | 1 | Campaign complete |

## Verification
The bench goes after three corner cases. The first is the pulse whose end runs past the period boundary: a wrong window compare would leave inject_o high into the compare cycle, or would cut the pulse a quantum early. The second is the order in which the loop counters wrap. A sequencer that reloaded the chain on a vector change, or nested widths inside targets, would put scan loads and vector values in the wrong cycles. The third is the mismatch window. The bench's model circuit differs only when the pulse covers the last quantum on a sensitive gate, so capturing a cycle early or late, or counting unlatched differences, shifts the count. The count is also driven past its maximum, where a wrapping counter would fall back to a small value. Start pulses are applied both during the run and after done, where any reaction would show up as extra scan loads.

// File: rtl/set_camp_pkg.sv
package set_camp_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_SCAN   = 3'd1,
        PH_SETTLE = 3'd2,
        PH_INJ    = 3'd3,
        PH_CMP    = 3'd4,
        PH_DONE   = 3'd5
    } camp_phase_e;

endpackage

// File: rtl/set_camp_pulse.sv
// Inject window decode: high for quanta inside [start, start + width),
// truncated at the end of the period by the caller's quantum range.
module set_camp_pulse #(
    parameter int PERIOD_Q = 16,
    parameter int N_WIDTHS = 3,
    parameter int W_MIN    = 2,
    parameter int W_STEP   = 4,
    localparam int TICK_W  = $clog2(PERIOD_Q) + 1,
    localparam int INST_W  = (PERIOD_Q > 1) ? $clog2(PERIOD_Q) : 1,
    localparam int WSEL_W  = (N_WIDTHS > 1) ? $clog2(N_WIDTHS) : 1
) (
    input  logic              active_i,
    input  logic [TICK_W-1:0] quantum_i,
    input  logic [INST_W-1:0] start_q_i,
    input  logic [WSEL_W-1:0] wsel_i,
    output logic              inject_o
);

    logic [31:0] width_val;
    logic [31:0] lo_bound;
    logic [31:0] hi_bound;
    logic [31:0] q_val;

    always_comb begin
        width_val = 32'(W_MIN) + 32'(wsel_i) * 32'(W_STEP);
        lo_bound  = 32'(start_q_i);
        hi_bound  = lo_bound + width_val;
        q_val     = 32'(quantum_i);
        inject_o  = active_i && (q_val >= lo_bound) && (q_val < hi_bound);
    end

endmodule

// File: rtl/set_camp_scan.sv
// One-hot mask serializer: the first bit shifted ends at the far end of
// the chain, so the one is sent in load cycle N_GATES-1-target.
module set_camp_scan #(
    parameter int N_GATES = 8,
    parameter int TICK_W  = 5,
    localparam int GATE_W = (N_GATES > 1) ? $clog2(N_GATES) : 1
) (
    input  logic              active_i,
    input  logic [TICK_W-1:0] load_cyc_i,
    input  logic [GATE_W-1:0] target_i,
    output logic              scan_en_o,
    output logic              scan_bit_o
);

    logic [31:0] hot_cyc;

    always_comb begin
        hot_cyc    = 32'(N_GATES - 1) - 32'(target_i);
        scan_en_o  = active_i;
        scan_bit_o = active_i && (32'(load_cyc_i) == hot_cyc);
    end

endmodule

// File: rtl/set_camp_err.sv
// Output capture registers and saturating mismatch counter.
module set_camp_err #(
    parameter int OUT_W = 4,
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_en_i,
    input  logic             cmp_en_i,
    input  logic [OUT_W-1:0] fault_i,
    input  logic [OUT_W-1:0] gold_i,
    output logic [CNT_W-1:0] count_o
);

    typedef struct packed {
        logic [OUT_W-1:0] cap_fault;
        logic [OUT_W-1:0] cap_gold;
        logic [CNT_W-1:0] count;
    } err_state_t;

    err_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cap_en_i) begin
            st_d.cap_fault = fault_i;
            st_d.cap_gold  = gold_i;
        end
        if (cmp_en_i && (st_q.cap_fault != st_q.cap_gold) && (st_q.count != '1)) begin
            st_d.count = st_q.count + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.count;

endmodule

// File: rtl/set_camp_ctrl.sv
module set_camp_ctrl
    import set_camp_pkg::*;
#(
    parameter int N_GATES   = 8,
    parameter int PERIOD_Q  = 16,
    parameter int N_WIDTHS  = 3,
    parameter int W_MIN     = 2,
    parameter int W_STEP    = 4,
    parameter int N_VECTORS = 300,
    parameter int VEC_W     = 9,
    parameter int OUT_W     = 4,
    parameter int CNT_W     = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [OUT_W-1:0] fault_out_i,
    input  logic [OUT_W-1:0] gold_out_i,
    output logic [VEC_W-1:0] vec_o,
    output logic             scan_en_o,
    output logic             scan_bit_o,
    output logic             inject_o,
    output logic [CNT_W-1:0] err_cnt_o,
    output logic             done_o
);

    localparam int SPAN   = (PERIOD_Q > N_GATES) ? PERIOD_Q : N_GATES;
    localparam int TICK_W = $clog2(SPAN) + 1;
    localparam int PTCK_W = $clog2(PERIOD_Q) + 1;
    localparam int GATE_W = (N_GATES > 1) ? $clog2(N_GATES) : 1;
    localparam int VIDX_W = (N_VECTORS > 1) ? $clog2(N_VECTORS) : 1;
    localparam int INST_W = (PERIOD_Q > 1) ? $clog2(PERIOD_Q) : 1;
    localparam int WSEL_W = (N_WIDTHS > 1) ? $clog2(N_WIDTHS) : 1;

    localparam logic [TICK_W-1:0] LAST_SCAN = TICK_W'(N_GATES - 1);
    localparam logic [TICK_W-1:0] LAST_Q    = TICK_W'(PERIOD_Q - 1);
    localparam logic [GATE_W-1:0] LAST_GATE = GATE_W'(N_GATES - 1);
    localparam logic [VIDX_W-1:0] LAST_VEC  = VIDX_W'(N_VECTORS - 1);
    localparam logic [INST_W-1:0] LAST_INST = INST_W'(PERIOD_Q - 1);
    localparam logic [WSEL_W-1:0] LAST_WSEL = WSEL_W'(N_WIDTHS - 1);

    typedef struct packed {
        camp_phase_e       phase;
        logic [TICK_W-1:0] tick;
        logic [GATE_W-1:0] gate;
        logic [VIDX_W-1:0] vidx;
        logic [INST_W-1:0] inst;
        logic [WSEL_W-1:0] wsel;
        logic [VEC_W-1:0]  vec;
    } seq_state_t;

    seq_state_t sq_d, sq_q;

    logic cap_en;
    logic cmp_en;

    // Sequencer: width > target > vector > instant, each instant being
    // settle period, injection period, one compare cycle.
    always_comb begin
        sq_d = sq_q;
        unique case (sq_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    sq_d.phase = PH_SCAN;
                    sq_d.tick  = '0;
                    sq_d.gate  = '0;
                    sq_d.vidx  = '0;
                    sq_d.inst  = '0;
                    sq_d.wsel  = '0;
                end
            end
            PH_SCAN: begin
                if (sq_q.tick == LAST_SCAN) begin
                    sq_d.phase = PH_SETTLE;
                    sq_d.tick  = '0;
                end else begin
                    sq_d.tick = sq_q.tick + TICK_W'(1);
                end
            end
            PH_SETTLE: begin
                if (sq_q.tick == LAST_Q) begin
                    sq_d.phase = PH_INJ;
                    sq_d.tick  = '0;
                end else begin
                    sq_d.tick = sq_q.tick + TICK_W'(1);
                end
            end
            PH_INJ: begin
                if (sq_q.tick == LAST_Q) begin
                    sq_d.phase = PH_CMP;
                    sq_d.tick  = '0;
                end else begin
                    sq_d.tick = sq_q.tick + TICK_W'(1);
                end
            end
            PH_CMP: begin
                sq_d.tick = '0;
                if (sq_q.inst != LAST_INST) begin
                    sq_d.inst  = sq_q.inst + INST_W'(1);
                    sq_d.phase = PH_SETTLE;
                end else begin
                    sq_d.inst = '0;
                    if (sq_q.vidx != LAST_VEC) begin
                        sq_d.vidx  = sq_q.vidx + VIDX_W'(1);
                        sq_d.phase = PH_SETTLE;
                    end else begin
                        sq_d.vidx = '0;
                        if (sq_q.gate != LAST_GATE) begin
                            sq_d.gate  = sq_q.gate + GATE_W'(1);
                            sq_d.phase = PH_SCAN;
                        end else begin
                            sq_d.gate = '0;
                            if (sq_q.wsel != LAST_WSEL) begin
                                sq_d.wsel  = sq_q.wsel + WSEL_W'(1);
                                sq_d.phase = PH_SCAN;
                            end else begin
                                sq_d.phase = PH_DONE;
                            end
                        end
                    end
                end
            end
            PH_DONE: begin
                sq_d.phase = PH_DONE;
            end
            default: begin
                sq_d.phase = PH_IDLE;
            end
        endcase

        // The input registers take the vector on every entry to settling.
        if ((sq_d.phase == PH_SETTLE) && (sq_q.phase != PH_SETTLE)) begin
            sq_d.vec = VEC_W'(sq_d.vidx);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sq_q <= '{phase: PH_IDLE, default: '0};
        end else begin
            sq_q <= sq_d;
        end
    end

    assign cap_en = (sq_q.phase == PH_INJ) && (sq_q.tick == LAST_Q);
    assign cmp_en = (sq_q.phase == PH_CMP);

    set_camp_scan #(
        .N_GATES (N_GATES),
        .TICK_W  (TICK_W)
    ) u_scan (
        .active_i   (sq_q.phase == PH_SCAN),
        .load_cyc_i (sq_q.tick),
        .target_i   (sq_q.gate),
        .scan_en_o  (scan_en_o),
        .scan_bit_o (scan_bit_o)
    );

    set_camp_pulse #(
        .PERIOD_Q (PERIOD_Q),
        .N_WIDTHS (N_WIDTHS),
        .W_MIN    (W_MIN),
        .W_STEP   (W_STEP)
    ) u_pulse (
        .active_i  (sq_q.phase == PH_INJ),
        .quantum_i (sq_q.tick[PTCK_W-1:0]),
        .start_q_i (sq_q.inst),
        .wsel_i    (sq_q.wsel),
        .inject_o  (inject_o)
    );

    set_camp_err #(
        .OUT_W (OUT_W),
        .CNT_W (CNT_W)
    ) u_err (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en_i (cap_en),
        .cmp_en_i (cmp_en),
        .fault_i  (fault_out_i),
        .gold_i   (gold_out_i),
        .count_o  (err_cnt_o)
    );

    assign vec_o  = sq_q.vec;
    assign done_o = (sq_q.phase == PH_DONE);

endmodule

// File: rtl/set_camp_chk.sv
module set_camp_chk #(
    parameter int VEC_W = 9,
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic [VEC_W-1:0] vec_o,
    input logic             scan_en_o,
    input logic             inject_o,
    input logic [CNT_W-1:0] err_cnt_o,
    input logic             done_o
);

    // R2
    scan_inject_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(scan_en_o && inject_o));

    // R3
    settle_after_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scan_en_o) |-> !inject_o);

    // R6
    vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inject_o |-> $stable(vec_o));

    // R7
    err_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_cnt_o != $past(err_cnt_o)) |-> (err_cnt_o == $past(err_cnt_o) + CNT_W'(1)));

    // R9
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (done_o && !inject_o && !scan_en_o));

endmodule

bind set_camp_ctrl set_camp_chk #(
    .VEC_W (VEC_W),
    .CNT_W (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .vec_o     (vec_o),
    .scan_en_o (scan_en_o),
    .inject_o  (inject_o),
    .err_cnt_o (err_cnt_o),
    .done_o    (done_o)
);

// File: tb/sim_set_camp_ctrl.sv
`timescale 1ns/1ps
module sim_set_camp_ctrl;

    localparam int NG    = 4;
    localparam int P     = 6;
    localparam int NW    = 2;
    localparam int WMIN  = 1;
    localparam int WSTEP = 2;
    localparam int NV    = 3;
    localparam int VW    = 4;
    localparam int OW    = 4;
    localparam int CW    = 4;
    localparam int CMAX  = (1 << CW) - 1;
    localparam logic [NG-1:0] SENS = 4'b1010;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start;
    logic [OW-1:0] fault_out;
    logic [OW-1:0] gold_out;
    logic [VW-1:0] vec;
    logic          scan_en;
    logic          scan_bit;
    logic          inject;
    logic [CW-1:0] err_cnt;
    logic          done;

    logic [NG-1:0] mask = '0;

    int checks   = 0;
    int failures = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    // Behavioural circuit model: the output differs from golden only while
    // a pulse is present on a sensitive gate.
    assign gold_out  = vec ^ 4'h5;
    assign fault_out = gold_out ^ {3'b000, inject & (|(mask & SENS))};

    set_camp_ctrl #(
        .N_GATES   (NG),
        .PERIOD_Q  (P),
        .N_WIDTHS  (NW),
        .W_MIN     (WMIN),
        .W_STEP    (WSTEP),
        .N_VECTORS (NV),
        .VEC_W     (VW),
        .OUT_W     (OW),
        .CNT_W     (CW)
    ) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .fault_out_i (fault_out),
        .gold_out_i  (gold_out),
        .vec_o       (vec),
        .scan_en_o   (scan_en),
        .scan_bit_o  (scan_bit),
        .inject_o    (inject),
        .err_cnt_o   (err_cnt),
        .done_o      (done)
    );

    typedef struct {
        int ph;   // 0 scan, 1 settle, 2 inject, 3 compare, 4 done
        int se;
        int sb;
        int inj;
        int vec;  // -1: not compared
        int err;
        int dn;
        int wk;
    } exp_t;

    exp_t trace[$];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic push(input int ph, input int se, input int sb, input int inj,
                        input int v, input int e, input int dn, input int wk);
        exp_t x;
        x.ph = ph; x.se = se; x.sb = sb; x.inj = inj;
        x.vec = v; x.err = e; x.dn = dn; x.wk = wk;
        trace.push_back(x);
    endtask

    task automatic build_trace();
        int e;
        e = 0;
        for (int k = 0; k < NW; k++) begin
            int w;
            w = WMIN + k * WSTEP;
            for (int g = 0; g < NG; g++) begin
                for (int c = 0; c < NG; c++)
                    push(0, 1, (c == NG - 1 - g) ? 1 : 0, 0, -1, e, 0, k);
                for (int v = 0; v < NV; v++) begin
                    for (int s = 0; s < P; s++) begin
                        for (int q = 0; q < P; q++) push(1, 0, 0, 0, v, e, 0, k);
                        for (int q = 0; q < P; q++)
                            push(2, 0, 0, (q >= s && q < s + w) ? 1 : 0, v, e, 0, k);
                        push(3, 0, 0, 0, v, e, 0, k);
                        if (SENS[g] && (s + w >= P) && (e < CMAX)) e++;
                    end
                end
            end
        end
        for (int i = 0; i < 6; i++) push(4, 0, 0, 0, -1, e, 1, NW - 1);
    endtask

    task automatic check_entry(input exp_t x);
        string itag;
        string etag;
        if (x.ph == 0)
            chk(scan_en == x.se[0], "R2 scan_en", int'(scan_en), x.se);
        else
            chk(scan_en == x.se[0], "R9 scan_en", int'(scan_en), x.se);
        chk(scan_bit == x.sb[0], "R2 scan_bit", int'(scan_bit), x.sb);
        if (x.ph == 1)      itag = "R3 inject";
        else if (x.ph == 2) itag = (x.wk > 0) ? "R5 inject" : "R4 inject";
        else if (x.ph == 0) itag = "R2 inject";
        else                itag = "R9 inject";
        chk(inject == x.inj[0], itag, int'(inject), x.inj);
        if (x.vec >= 0)
            chk(int'(vec) == x.vec, "R6 vec", int'(vec), x.vec);
        etag = (x.err == CMAX) ? "R8 err_cnt" : "R7 err_cnt";
        chk(int'(err_cnt) == x.err, etag, int'(err_cnt), x.err);
        chk(done == x.dn[0], "R9 done", int'(done), x.dn);
    endtask

    initial begin
        int n;
        exp_t x;
        rst_n = 1'b0;
        start = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state and idle without start
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(vec == '0, "R1 vec", int'(vec), 0);
            chk(!scan_en && !scan_bit, "R1 scan", int'(scan_en), 0);
            chk(!inject, "R1 inject", int'(inject), 0);
            chk(err_cnt == '0, "R1 err_cnt", int'(err_cnt), 0);
            chk(!done, "R1 done", int'(done), 0);
        end
        build_trace();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (trace.size() > 0) begin
            x = trace.pop_front();
            check_entry(x);
            if (scan_en) mask = {mask[NG-2:0], scan_bit};
            // R10: start pulses mid-run must not disturb the sequence
            start = (n == 120 || n == 700) ? 1'b1 : 1'b0;
            n++;
            @(negedge clk);
        end
        // R8: final count saturated
        chk(int'(err_cnt) == CMAX, "R8 saturated", int'(err_cnt), CMAX);
        // R10: start after done is ignored
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(done, "R10 done", int'(done), 1);
            chk(!scan_en, "R10 scan_en", int'(scan_en), 0);
            chk(int'(err_cnt) == CMAX, "R10 err_cnt", int'(err_cnt), CMAX);
        end
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule